// File: doc/BRIEF.md
# First-Hit Channel Address Reporter

The block watches the trigger lines of 64 channels and announces which channel fired first. Each channel has two lines: one goes high at a threshold crossing and one goes high when a peak is found. A mode input chooses which of the two sets counts as a trigger. When the chosen set shows activity while the block is armed, the block takes the index of the winning channel. It then sends a report on one serial wire: a single high start bit, followed by the 6-bit channel index.

Downstream logic watches the serial wire for the start bit and then collects six bits, one per clock. The busy output tells the system that a report is being sent, or that the block is waiting for the trigger lines to clear before it arms again. Later hits are not queued. Only the earliest one is reported.

Top module: `first_hit_reporter`

States of the controller: IDLE (armed), FLAG (start bit on the wire), SHIFT (address bits on the wire) and REARM (waiting for the selected lines to go low). Transitions:
- IDLE→FLAG when any selected line is high at a clock edge.
- FLAG→SHIFT always.
- SHIFT→SHIFT until the sixth bit has been sent.
- SHIFT→IDLE after the sixth bit, if no selected line is high.
- SHIFT→REARM after the sixth bit, if a selected line is high.
- REARM→IDLE at the first edge with all selected lines low.

## Requirements
- R1: After reset the block is idle and armed. Busy is low, and the serial line is low whenever busy is low.
- R2: With trig_mode=0 only thr_hit lines trigger, and with trig_mode=1 only peak_hit lines trigger. The other set has no effect on the output.
- R3: A trigger seen at clock edge k makes ser_out high for exactly the cycle after edge k (the start bit). The six address bits follow on the next six cycles, most significant bit first, one bit per clock.
- R4: When several selected lines are high at the triggering edge, the lowest-numbered channel is reported.
- R5: Lines that change while the start bit or the address bits are on the wire are ignored. The reported address is the one captured at the triggering edge.
- R6: After the last address bit the block re-arms only at the first edge where all selected lines are low. Until then busy stays high and ser_out stays low. If the lines are already low at the edge that ends the last bit, the block is idle in the next cycle.
- R7: Busy is high from the start-bit cycle through the last address bit, and through any re-arm wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_mode | input | 1 | 0: threshold lines trigger, 1: peak lines trigger |
| thr_hit | input | 64 | Per-channel threshold-crossing lines |
| peak_hit | input | 64 | Per-channel peak-found lines |
| ser_out | output | 1 | Serial report: start bit, then address MSB first; idles low |
| busy | output | 1 | High while a report is sent or re-arming |

## Verification
Two functions can fall on the same clock edge. The first is the multi-channel tie, where several lines rise together and the priority choice must pick the lowest index. The second is the end of a report meeting the re-arm decision, where the last address bit leaves the wire in the same cycle that the selected lines are tested. Ties are provoked directly: channel 0 and channel 63 fire together, and random sparse masks often carry several set bits. Each frame is compared bit by bit with an index computed by a bench function. The end-of-report edge is exercised two ways. In some frames the lines are released exactly on the last bit, and busy must fall one cycle later. In other frames the lines are held past the report, and busy must stay high with a silent wire until they are released.

// File: rtl/fhr_pkg.sv
package fhr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLAG  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_REARM = 2'd3
    } fhr_state_e;
endpackage

// File: rtl/fhr_line_select.sv
module fhr_line_select #(
    parameter int NCH = 64
) (
    input  logic           use_peak,
    input  logic [NCH-1:0] thr_lines,
    input  logic [NCH-1:0] peak_lines,
    output logic [NCH-1:0] chosen,
    output logic           any_set
);
    assign chosen  = use_peak ? peak_lines : thr_lines;
    assign any_set = |chosen;
endmodule

// File: rtl/fhr_prio_enc.sv
module fhr_prio_enc #(
    parameter int NCH = 64,
    parameter int AW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic [AW-1:0]  idx
);
    // Scan from the top down so the lowest set index is written last.
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
    end
endmodule

// File: rtl/first_hit_reporter.sv
module first_hit_reporter #(
    parameter int NCH = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trig_mode,
    input  logic [NCH-1:0] thr_hit,
    input  logic [NCH-1:0] peak_hit,
    output logic           ser_out,
    output logic           busy
);
    import fhr_pkg::*;

    localparam int AW = $clog2(NCH);
    localparam int CW = (AW > 1) ? $clog2(AW) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(AW - 1);

    logic [NCH-1:0] sel_lines;
    logic           sel_any;
    logic [AW-1:0]  win_idx;

    fhr_state_e     state_q, state_d;
    logic [AW-1:0]  addr_q;
    logic [CW-1:0]  cnt_q;
    logic           last_bit;

    fhr_line_select #(.NCH(NCH)) u_sel (
        .use_peak   (trig_mode),
        .thr_lines  (thr_hit),
        .peak_lines (peak_hit),
        .chosen     (sel_lines),
        .any_set    (sel_any)
    );

    fhr_prio_enc #(.NCH(NCH), .AW(AW)) u_enc (
        .req (sel_lines),
        .idx (win_idx)
    );

    assign last_bit = (cnt_q == LAST_BIT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sel_any) state_d = ST_FLAG;
            ST_FLAG:  state_d = ST_SHIFT;
            ST_SHIFT: if (last_bit) state_d = sel_any ? ST_REARM : ST_IDLE;
            ST_REARM: if (!sel_any) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Address capture and shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (state_q == ST_IDLE && sel_any) begin
            addr_q <= win_idx;
            cnt_q  <= '0;
        end else if (state_q == ST_SHIFT) begin
            addr_q <= addr_q << 1;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        ser_out = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_FLAG:  ser_out = 1'b1;
            ST_SHIFT: ser_out = addr_q[AW-1];
            ST_REARM: ser_out = 1'b0;
            default:  busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/fhr_checker.sv
module fhr_checker (
    input logic                clk,
    input logic                rst_n,
    input logic                ser_out,
    input logic                busy,
    input logic                sel_any,
    input fhr_pkg::fhr_state_e state_q
);
    import fhr_pkg::*;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_out);

    a_r3_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sel_any) |=> (ser_out && busy));

    a_r3_flag_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLAG) |=> (state_q == ST_SHIFT));

    a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |=> (state_q != ST_FLAG));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REARM && sel_any) |=> (busy && !ser_out));

    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REARM && !sel_any) |=> !busy);
endmodule

bind first_hit_reporter fhr_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_out (ser_out),
    .busy    (busy),
    .sel_any (sel_any),
    .state_q (state_q)
);

// File: tb/first_hit_reporter_bench.sv
module first_hit_reporter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_mode = 1'b0;
    logic [63:0] thr_hit = '0;
    logic [63:0] peak_hit = '0;
    logic        ser_out;
    logic        busy;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    first_hit_reporter u_first_hit_reporter (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_mode (trig_mode),
        .thr_hit   (thr_hit),
        .peak_hit  (peak_hit),
        .ser_out   (ser_out),
        .busy      (busy)
    );

    function automatic logic [5:0] lowest(input logic [63:0] v);
        for (int i = 63; i >= 0; i--) if (v[i]) lowest = 6'(i);
        if (v == '0) lowest = '0;
    endfunction

    function automatic logic [63:0] sparse();
        logic [63:0] v;
        v = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        if (v == '0) v[$urandom % 64] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one trigger and check the complete frame.
    // hold=0: lines carry noise during the report and are released on the last bit.
    // hold=1: lines stay unchanged throughout, so the block must wait to re-arm.
    task automatic frame(input logic md, input logic [63:0] t, input logic [63:0] p, input bit hold);
        logic [5:0] exp;
        exp = lowest(md ? p : t);
        trig_mode = md; thr_hit = t; peak_hit = p;
        @(negedge clk);
        chk("R3 flag", ser_out, 1'b1);
        chk("R7 busy flag", busy, 1'b1);
        for (int b = 5; b >= 0; b--) begin
            if (!hold) begin
                thr_hit = sparse(); peak_hit = sparse();   // R5 noise is ignored
            end
            @(negedge clk);
            chk("R3/R4/R5 addr bit", ser_out, exp[b]);
            chk("R7 busy shift", busy, 1'b1);
        end
        if (!hold) begin
            thr_hit = '0; peak_hit = '0;
            @(negedge clk);
            chk("R6 idle after release", busy, 1'b0);
            chk("R1 line low idle", ser_out, 1'b0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy reset", busy, 1'b0);
        chk("R1 ser reset", ser_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", busy, 1'b0);

        // R2: unselected set is ignored
        trig_mode = 1'b0; peak_hit = 64'hFFFF_0000_FFFF_0000;
        repeat (3) begin
            @(negedge clk);
            chk("R2 peak ignored in thr mode", busy, 1'b0);
            chk("R2 wire quiet", ser_out, 1'b0);
        end
        peak_hit = '0; trig_mode = 1'b1; thr_hit = 64'h0F0F;
        repeat (2) begin
            @(negedge clk);
            chk("R2 thr ignored in peak mode", busy, 1'b0);
        end
        thr_hit = '0;

        // R4: tie between channel 0 and 63; single top channel; mid channel
        frame(1'b0, 64'h8000_0000_0000_0001, '0, 1'b0);
        frame(1'b0, 64'h8000_0000_0000_0000, '0, 1'b0);
        frame(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1 << 42, 1'b0);

        // R6: lines held past the report
        frame(1'b0, 64'h0000_0100_0000_0000, '0, 1'b1);
        repeat (3) begin
            @(negedge clk);
            chk("R6 busy while held", busy, 1'b1);
            chk("R6 wire low while held", ser_out, 1'b0);
        end
        trig_mode = 1'b1;           // re-arm test follows the current mode
        @(negedge clk);
        chk("R6 re-armed after lines low", busy, 1'b0);
        thr_hit = '0;
        @(negedge clk);
        chk("R1 stays idle", busy, 1'b0);

        // Random frames
        for (int n = 0; n < 60; n++) begin
            logic md;
            md = 1'($urandom);
            frame(md, sparse(), sparse(), 1'b0);
            repeat ($urandom % 3) @(negedge clk);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule